// File: doc/BRIEF.md
# Zoned Bandwidth Monitor

This block measures how much data a port moves in a repeating time slot and grades each slot against three programmable thresholds. A byte count arriving with a valid strobe is added each clock into a saturating accumulator. A window timer counts ticks of an external sampling timer. When the programmed number of ticks has elapsed, the accumulated total is scaled down into count units and latched as the window's sample, and the accumulator restarts from zero.

In the following cycle the sample is sorted into one of four zones. The action field of that zone then increments or clears any of the four per-zone hit counters. The zone's maximum register is updated. A zone whose hit counter climbs to its programmed limit sets its interrupt status bit. A single level interrupt output reflects the status bits that are enabled.

Software programs and observes the block through a 32-bit word-addressed write/read port. Reads are combinational.

Top module: `zbw_monitor`

## Requirements
- R1: Ticks are counted only while the monitor is enabled. A window ends on the tick that brings the tick count to the programmed length at word 5, and a length of 0 behaves as 1. Bytes presented in that tick's cycle belong to the ending window. The window's results can be read two clock edges after that cycle.
- R2: The accumulator adds `xferBytes` whenever `xferValid` is high. The window sample equals the accumulated bytes divided by 2^UNIT_SHIFT and rounded down. The accumulator saturates instead of wrapping, so the largest possible sample is 4095.
- R3: Thresholds are written at word 8 (low), word 7 (medium) and word 6 (high). A sample below low falls in zone 0, a sample below medium in zone 1, a sample below high in zone 2, and any other sample in zone 3. A sample equal to a threshold falls in the higher zone.
- R4: Word 9 holds one 8-bit action field per zone, with zone z at bits [8z+7:8z]. Within the field of the classified zone, the 2-bit slot at bits [2t+1:2t] acts on hit counter t. Slot value 2'b10 increments the counter and 2'b01 clears it. Value 2'b11 also clears it, and 2'b00 leaves it unchanged.
- R5: Hit counters saturate at 255. Word 10 holds an 8-bit hit limit per zone, with zone t at bits [8t+7:8t]. Status bit t sets when an increment makes hit counter t equal to its limit. A limit of 0xFF never sets the status bit.
- R6: Words 12 to 15 read the maximum sample recorded for zones 0 to 3. Each maximum is updated only by windows classified into its own zone, and reading it has no side effect.
- R7: Word 0 reads the 4-bit status, with bit z belonging to zone z. A status bit sets regardless of its enable bit. Word 2 holds the 4-bit enable, and `irqOut` is high exactly when an enabled status bit is set.
- R8: Writing ones to word 1 clears the matching status bits, and word 1 reads as zero. If a clear and a set of the same bit fall in the same cycle, the bit stays set.
- R9: Word 4 reads as zero. Writing bit 0 clears the accumulator and the tick count, and it drops a window ending in that same cycle. Writing bit 1 does the same and also zeroes every maximum and hit counter. Neither write changes the status.
- R10: Bit 0 of word 3 enables the monitor. While it is clear, the tick count and the accumulator hold their values.
- R11: After reset, all registers, counters, maximums and status bits are zero, and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferValid | input | 1 | Byte count on `xferBytes` is valid this cycle |
| xferBytes | input | BYTE_W | Bytes transferred this cycle |
| tick | input | 1 | One pulse per sampling-timer period |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Level interrupt |

## Verification
The status register has two writers that can act in the same cycle: the evaluation of a finished window can set a bit, and a write-one-to-clear access can clear it. The bench first leaves a zone's status bit set and resets the hit counters with a full clear. It then ends a window into that zone and places the clear write exactly on the evaluation edge, one cycle after the final tick. The bit must still read one afterwards. A later plain clear write must bring it to zero.

// File: rtl/zbw_pkg.sv
package zbw_pkg;
  localparam int NZONE = 4;
  localparam int SLOT_W = 2;
  localparam int ACT_W = SLOT_W * NZONE;

  localparam logic [3:0] REG_STATUS = 4'd0;
  localparam logic [3:0] REG_IRQCLR = 4'd1;
  localparam logic [3:0] REG_IRQEN  = 4'd2;
  localparam logic [3:0] REG_ENABLE = 4'd3;
  localparam logic [3:0] REG_CTLCLR = 4'd4;
  localparam logic [3:0] REG_WINDOW = 4'd5;
  localparam logic [3:0] REG_THRHI  = 4'd6;
  localparam logic [3:0] REG_THRMED = 4'd7;
  localparam logic [3:0] REG_THRLO  = 4'd8;
  localparam logic [3:0] REG_ACTION = 4'd9;
  localparam logic [3:0] REG_HITLIM = 4'd10;
  localparam logic [3:0] REG_MAX0   = 4'd12;

  typedef struct packed {
    logic             snap;    // window ends: latch sample, restart accumulator
    logic             eval;    // classify latched sample
    logic             clrRun;  // clear running counters
    logic             clrAll;  // also clear maximums and hit counters
    logic [NZONE-1:0] irqClr;  // write-one-to-clear of status
  } zbwStrobe_t;
endpackage

// File: rtl/zbw_ctrl.sv
module zbw_ctrl
  import zbw_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int THR_W = 12,
  parameter int HIT_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   regWrEn,
  input  logic [3:0]             regAddr,
  input  logic [31:0]            regWrData,
  input  logic [NZONE-1:0]       statusIn,
  input  logic [NZONE*THR_W-1:0] maxIn,
  output logic [31:0]            regRdData,
  output logic                   monEn,
  output logic [NZONE-1:0]       irqEn,
  output logic [THR_W-1:0]       thrLo,
  output logic [THR_W-1:0]       thrMed,
  output logic [THR_W-1:0]       thrHi,
  output logic [NZONE*ACT_W-1:0] actions,
  output logic [NZONE*HIT_W-1:0] hitLimit,
  output zbwStrobe_t             strb
);
  logic [WIN_W-1:0] winLen;
  logic [WIN_W-1:0] tickCnt;
  logic [WIN_W:0]   tickNext;
  logic [WIN_W:0]   winEff;
  logic             windowDone;
  logic             evalQ;
  logic             ctlWr;

  assign ctlWr = regWrEn && (regAddr == REG_CTLCLR);

  // window timer
  assign tickNext   = {1'b0, tickCnt} + 1'b1;
  assign winEff     = (winLen == '0) ? (WIN_W+1)'(1) : {1'b0, winLen};
  assign windowDone = monEn && tick && (tickNext >= winEff);

  always_comb begin
    strb.clrRun = ctlWr && (regWrData[0] || regWrData[1]);
    strb.clrAll = ctlWr && regWrData[1];
    strb.snap   = windowDone && !strb.clrRun;
    strb.eval   = evalQ;
    strb.irqClr = (regWrEn && (regAddr == REG_IRQCLR)) ? regWrData[NZONE-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      evalQ   <= 1'b0;
    end else begin
      evalQ <= strb.snap;
      if (strb.clrRun || windowDone) tickCnt <= '0;
      else if (monEn && tick)        tickCnt <= tickNext[WIN_W-1:0];
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      monEn    <= 1'b0;
      irqEn    <= '0;
      winLen   <= '0;
      thrLo    <= '0;
      thrMed   <= '0;
      thrHi    <= '0;
      actions  <= '0;
      hitLimit <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_ENABLE: monEn    <= regWrData[0];
        REG_IRQEN:  irqEn    <= regWrData[NZONE-1:0];
        REG_WINDOW: winLen   <= regWrData[WIN_W-1:0];
        REG_THRLO:  thrLo    <= regWrData[THR_W-1:0];
        REG_THRMED: thrMed   <= regWrData[THR_W-1:0];
        REG_THRHI:  thrHi    <= regWrData[THR_W-1:0];
        REG_ACTION: actions  <= regWrData[NZONE*ACT_W-1:0];
        REG_HITLIM: hitLimit <= regWrData[NZONE*HIT_W-1:0];
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_STATUS: regRdData = 32'(statusIn);
      REG_IRQEN:  regRdData = 32'(irqEn);
      REG_ENABLE: regRdData = 32'(monEn);
      REG_WINDOW: regRdData = 32'(winLen);
      REG_THRLO:  regRdData = 32'(thrLo);
      REG_THRMED: regRdData = 32'(thrMed);
      REG_THRHI:  regRdData = 32'(thrHi);
      REG_ACTION: regRdData = 32'(actions);
      REG_HITLIM: regRdData = 32'(hitLimit);
      default:    regRdData = '0;
    endcase
    for (int z = 0; z < NZONE; z++) begin
      if (regAddr == 4'(int'(REG_MAX0) + z)) regRdData = 32'(maxIn[z*THR_W +: THR_W]);
    end
  end
endmodule

// File: rtl/zbw_datapath.sv
module zbw_datapath
  import zbw_pkg::*;
#(
  parameter int BYTE_W     = 16,
  parameter int UNIT_SHIFT = 6,
  parameter int THR_W      = 12,
  parameter int HIT_W      = 8,
  localparam int ACC_W     = THR_W + UNIT_SHIFT
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   xferValid,
  input  logic [BYTE_W-1:0]      xferBytes,
  input  logic                   monEn,
  input  logic [NZONE-1:0]       irqEn,
  input  logic [THR_W-1:0]       thrLo,
  input  logic [THR_W-1:0]       thrMed,
  input  logic [THR_W-1:0]       thrHi,
  input  logic [NZONE*ACT_W-1:0] actions,
  input  logic [NZONE*HIT_W-1:0] hitLimit,
  input  zbwStrobe_t             strb,
  output logic [NZONE-1:0]       statusVec,
  output logic [NZONE*THR_W-1:0] maxFlat,
  output logic [NZONE*HIT_W-1:0] hitFlat,
  output logic [ACC_W-1:0]       accLevel,
  output logic                   irqOut
);
  localparam int SUM_W = ((ACC_W > BYTE_W) ? ACC_W : BYTE_W) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accIn;
  logic [SUM_W-1:0] sumWide;
  logic [THR_W-1:0] sampleQ;
  logic [1:0]       zoneSel;
  logic [ACT_W-1:0] actSlice;

  // saturating accumulator
  assign sumWide = SUM_W'(accQ) + SUM_W'(xferBytes);
  assign accSum  = (sumWide > SUM_W'(ACC_MAX)) ? ACC_MAX : sumWide[ACC_W-1:0];
  assign accIn   = (monEn && xferValid) ? accSum : accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      sampleQ <= '0;
    end else begin
      if (strb.clrRun || strb.snap) accQ <= '0;
      else                          accQ <= accIn;
      if (strb.snap) sampleQ <= accIn[ACC_W-1:UNIT_SHIFT];
    end
  end

  // zone classification, equality goes to the upper zone
  always_comb begin
    if (sampleQ < thrLo)       zoneSel = 2'd0;
    else if (sampleQ < thrMed) zoneSel = 2'd1;
    else if (sampleQ < thrHi)  zoneSel = 2'd2;
    else                       zoneSel = 2'd3;
  end

  assign actSlice = actions[int'(zoneSel)*ACT_W +: ACT_W];

  for (genvar t = 0; t < NZONE; t++) begin : g_zone
    logic [SLOT_W-1:0] slot;
    logic [HIT_W-1:0]  hitQ;
    logic [HIT_W-1:0]  limit;
    logic [THR_W-1:0]  maxQ;
    logic              statBit;
    logic              bump;
    logic              wipe;
    logic              atTop;
    logic              reach;

    assign slot  = actSlice[SLOT_W*t +: SLOT_W];
    assign wipe  = slot[0];
    assign bump  = (slot == 2'b10);
    assign limit = hitLimit[t*HIT_W +: HIT_W];
    assign atTop = &hitQ;
    assign reach = strb.eval && bump && !atTop &&
                   ((hitQ + 1'b1) == limit) && !(&limit);

    always_ff @(posedge clk) begin
      if (!rstN)                    hitQ <= '0;
      else if (strb.clrAll)         hitQ <= '0;
      else if (strb.eval && wipe)   hitQ <= '0;
      else if (strb.eval && bump && !atTop) hitQ <= hitQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) statBit <= 1'b0;
      else       statBit <= (statBit && !strb.irqClr[t]) || reach;
    end

    always_ff @(posedge clk) begin
      if (!rstN)            maxQ <= '0;
      else if (strb.clrAll) maxQ <= '0;
      else if (strb.eval && (zoneSel == 2'(t)) && (sampleQ > maxQ)) maxQ <= sampleQ;
    end

    assign statusVec[t]               = statBit;
    assign maxFlat[t*THR_W +: THR_W]  = maxQ;
    assign hitFlat[t*HIT_W +: HIT_W]  = hitQ;
  end

  assign accLevel = accQ;
  assign irqOut   = |(statusVec & irqEn);
endmodule

// File: rtl/zbw_monitor.sv
module zbw_monitor
  import zbw_pkg::*;
#(
  parameter int BYTE_W     = 16,
  parameter int UNIT_SHIFT = 6,
  parameter int WIN_W      = 24,
  parameter int THR_W      = 12,
  parameter int HIT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferValid,
  input  logic [BYTE_W-1:0] xferBytes,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);
  localparam int ACC_W = THR_W + UNIT_SHIFT;

  zbwStrobe_t             strb;
  logic                   monEn;
  logic [NZONE-1:0]       irqEn;
  logic [THR_W-1:0]       thrLo;
  logic [THR_W-1:0]       thrMed;
  logic [THR_W-1:0]       thrHi;
  logic [NZONE*ACT_W-1:0] actions;
  logic [NZONE*HIT_W-1:0] hitLimit;
  logic [NZONE-1:0]       statusVec;
  logic [NZONE*THR_W-1:0] maxFlat;
  logic [NZONE*HIT_W-1:0] hitFlat;
  logic [ACC_W-1:0]       accLevel;

  zbw_ctrl #(.WIN_W(WIN_W), .THR_W(THR_W), .HIT_W(HIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .statusIn(statusVec), .maxIn(maxFlat), .regRdData(regRdData),
    .monEn(monEn), .irqEn(irqEn), .thrLo(thrLo), .thrMed(thrMed), .thrHi(thrHi),
    .actions(actions), .hitLimit(hitLimit), .strb(strb)
  );

  zbw_datapath #(.BYTE_W(BYTE_W), .UNIT_SHIFT(UNIT_SHIFT), .THR_W(THR_W), .HIT_W(HIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferBytes(xferBytes),
    .monEn(monEn), .irqEn(irqEn), .thrLo(thrLo), .thrMed(thrMed), .thrHi(thrHi),
    .actions(actions), .hitLimit(hitLimit), .strb(strb),
    .statusVec(statusVec), .maxFlat(maxFlat), .hitFlat(hitFlat),
    .accLevel(accLevel), .irqOut(irqOut)
  );
endmodule

// File: rtl/zbw_monitor_chk.sv
module zbw_monitor_chk
  import zbw_pkg::*;
#(
  parameter int ACC_W = 18,
  parameter int THR_W = 12,
  parameter int HIT_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   monEn,
  input zbwStrobe_t             strb,
  input logic [ACC_W-1:0]       accQ,
  input logic [NZONE*HIT_W-1:0] hitFlat,
  input logic [NZONE*THR_W-1:0] maxFlat,
  input logic [NZONE-1:0]       statusQ
);
  // R2: the accumulator never wraps; it only grows or restarts at zero
  a_r2_acc_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((accQ >= $past(accQ)) || (accQ == '0)));

  // R10: with the monitor disabled and no clear, the accumulator is frozen
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!monEn && !strb.clrRun) |=> $stable(accQ));

  // R5: hit counters move only on an evaluation or a full clear
  a_r5_hits_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.eval && !strb.clrAll) |=> $stable(hitFlat));

  // R7: a status bit rises only after an evaluation cycle
  a_r7_status_source: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & ~$past(statusQ))) |-> $past(strb.eval));

  // R9: a full clear zeroes every maximum and hit counter
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> ((maxFlat == '0) && (hitFlat == '0)));

  // R6: maximums never decrease without a full clear
  for (genvar z = 0; z < NZONE; z++) begin : g_max
    a_r6_max_monotone: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clrAll |=> (maxFlat[z*THR_W +: THR_W] >= $past(maxFlat[z*THR_W +: THR_W])));
  end
endmodule

bind zbw_monitor zbw_monitor_chk #(.ACC_W(ACC_W), .THR_W(THR_W), .HIT_W(HIT_W)) u_chk (
  .clk(clk), .rstN(rstN), .monEn(monEn), .strb(strb), .accQ(accLevel),
  .hitFlat(hitFlat), .maxFlat(maxFlat), .statusQ(statusVec)
);

// File: tb/zbw_monitor_tb.sv
module zbw_monitor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferValid = 1'b0;
  logic [15:0] xferBytes = '0;
  logic        tick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int NVEC = 8;
  localparam int VU[NVEC] = '{5, 10, 19, 20, 29, 30, 1000, 0};
  localparam int VZ[NVEC] = '{0, 1, 1, 2, 2, 3, 3, 0};
  localparam logic [31:0] ACT_SELF = 32'h8020_0802; // zone z increments counter z
  localparam logic [31:0] LIM_ONE  = 32'h0101_0101;

  always #5 clk = ~clk;

  zbw_monitor u_dut (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .xferBytes(xferBytes), .tick(tick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tickOnce(input int bytes);
    @(negedge clk);
    xferValid = 1'b1; xferBytes = 16'(bytes); tick = 1'b1;
    @(negedge clk);
    xferValid = 1'b0; xferBytes = '0; tick = 1'b0;
  endtask

  // one-tick window; returns at the negedge after the evaluation edge
  task automatic pulse(input int bytes);
    tickOnce(bytes);
    @(negedge clk);
  endtask

  task automatic fresh();
    wr(4'd4, 32'h2);
    wr(4'd1, 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(4'd0, v);  check("R11 status", v, 0);
    check("R11 irqOut", 32'(irqOut), 0);
    rd(4'd12, v); check("R11 max0", v, 0);
    rd(4'd5, v);  check("R11 window", v, 0);

    // configure
    wr(4'd8, 10); wr(4'd7, 20); wr(4'd6, 30);
    wr(4'd9, ACT_SELF); wr(4'd10, LIM_ONE);
    wr(4'd5, 1); wr(4'd3, 1);

    // R3 / R6 vector table
    for (int i = 0; i < NVEC; i++) begin
      fresh();
      pulse(VU[i] * 64);
      rd(4'd0, v); check("R3 zone status", v, 32'(1) << VZ[i]);
      rd(4'(12 + VZ[i]), v); check("R6 zone max", v, VU[i]);
    end

    // R2 floor division
    fresh();
    pulse(127);
    rd(4'd12, v); check("R2 floor", v, 1);

    // R2 saturation
    fresh();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); xferValid = 1'b1; xferBytes = 16'hFFFF;
    end
    @(negedge clk); xferValid = 1'b0; xferBytes = '0;
    pulse(0);
    rd(4'd15, v); check("R2 saturate max3", v, 4095);
    rd(4'd0, v);  check("R2 saturate zone3", v, 8);

    // R1 window of three ticks
    fresh();
    wr(4'd5, 3);
    tickOnce(64); tickOnce(64);
    @(negedge clk);
    rd(4'd0, v); check("R1 not yet ended", v, 0);
    tickOnce(64);
    @(negedge clk);
    rd(4'd0, v);  check("R1 ended status", v, 1);
    rd(4'd12, v); check("R1 three units", v, 3);

    // R9 running clear mid-window
    fresh();
    wr(4'd5, 2);
    tickOnce(640);
    wr(4'd4, 1);
    tickOnce(64); tickOnce(64);
    @(negedge clk);
    rd(4'd12, v); check("R9 restart max0", v, 2);
    rd(4'd13, v); check("R9 no stale window", v, 0);
    wr(4'd4, 2);
    rd(4'd12, v); check("R9 clear all max", v, 0);
    rd(4'd4, v);  check("R9 reads zero", v, 0);
    rd(4'd1, v);  check("R8 reads zero", v, 0);

    // R10 frozen while disabled
    fresh();
    wr(4'd5, 1);
    wr(4'd3, 0);
    tickOnce(6400); tickOnce(6400); tickOnce(6400);
    @(negedge clk);
    rd(4'd0, v);  check("R10 no window", v, 0);
    wr(4'd3, 1);
    pulse(64);
    rd(4'd12, v); check("R10 nothing held", v, 1);

    // R4 clear action
    fresh();
    wr(4'd9, 32'h8400_0800);
    wr(4'd10, 32'hFF00_0200);
    pulse(15 * 64); pulse(40 * 64); pulse(15 * 64);
    rd(4'd0, v); check("R4 clear slot", v, 0);
    pulse(15 * 64);
    rd(4'd0, v); check("R4 increment reaches limit", v, 2);

    // R5 limit 0xFF never fires
    wr(4'd9, ACT_SELF);
    wr(4'd10, 32'h0101_01FF);
    fresh();
    for (int i = 0; i < 256; i++) pulse(0);
    rd(4'd0, v); check("R5 limit FF", v, 0);

    // R7 enable gating
    wr(4'd10, LIM_ONE);
    fresh();
    wr(4'd2, 32'h2);
    pulse(5 * 64);
    rd(4'd0, v); check("R7 status w/o enable", v, 1);
    check("R7 irq masked", 32'(irqOut), 0);
    pulse(15 * 64);
    check("R7 irq raised", 32'(irqOut), 1);
    wr(4'd1, 32'h2);
    check("R8 irq cleared", 32'(irqOut), 0);
    rd(4'd0, v); check("R8 other bit kept", v, 1);

    // R8 set beats clear in the same cycle
    fresh();
    pulse(15 * 64);
    wr(4'd4, 2);
    rd(4'd0, v); check("R9 status untouched", v, 2);
    @(negedge clk);
    xferValid = 1'b1; xferBytes = 16'(15 * 64); tick = 1'b1;
    @(negedge clk);
    xferValid = 1'b0; xferBytes = '0; tick = 1'b0;
    regWrEn = 1'b1; regAddr = 4'd1; regWrData = 32'h2;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    rd(4'd0, v); check("R8 set wins", v, 2);
    wr(4'd1, 32'h2);
    rd(4'd0, v); check("R8 plain clear", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule